// File: doc/BRIEF.md
# AUX Request Header Formatter

This block sits between a requester and an AUX channel engine. It accepts one AUX transaction request, made of a request code, a 20-bit target address and a payload length, and turns it into the byte stream the engine sends on the wire. For writes, the payload bytes are pulled from a valid/ready stream and appended after the header. When the engine reports back, the block decodes the status byte and forwards any read data to the requester. It then presents a completion record. The record holds the reply code, the number of bytes the transaction produced and an error class.

Only one transaction is handled at a time. A request that is too long, or whose code is not a read or write, is completed at once with an error class and never reaches the engine. The completion record stays on the outputs until the requester acknowledges it. No new request is taken until then.

Top module: `aux_req_fmt`

## Requirements
- R1: The first three transmitted bytes are address bits 7:0, then address bits 15:8, then a byte holding the request code in bits 7:4 and address bits 19:16 in bits 3:0.
- R2: Bits 3:0 of the fourth transmitted byte hold the payload length minus one, or 0 when the length is 0.
- R3: Bits 7:4 of the fourth byte hold 3 for a zero-length request. Otherwise they hold 4 for a read, and for a write the low four bits of 4 plus the length (a 16-byte write gives 4).
- R4: A write of nonzero length sends the four header bytes followed by exactly its payload bytes, taken in order from the write-data stream. A read or a zero-length request sends only the four header bytes. tx_last_o marks the final byte, and the stream holds its byte under backpressure.
- R5: A length above 16 completes with error class 4 and count 0, and no byte is transmitted. This check takes priority over R6.
- R6: Bit 2 of the request code is the continuation flag and is masked off. The masked code must be 0 (I2C write), 1 (I2C read), 8 (native write) or 9 (native read). Any other code completes with error class 5 and count 0, and no byte is transmitted.
- R7: A status byte of exactly 1, 2 or 3 completes with error class 1 (timeout), 2 (flags set) or 3 (link error) respectively, with count 0 and reply 0. No read data is forwarded.
- R8: A successful read reports min(engine byte count, requested length) as its count. Only that many of the engine's data bytes are forwarded on rd_valid_o, in order. The rest are consumed and dropped.
- R9: A successful write reports the requested length as its count.
- R10: On success, the reply code is bits 7:4 of the status byte, and the error class is 0.
- R11: From acceptance until done_ack_i, req_ready_o is low and requests are ignored. The completion record is held stable while done_valid_o is high and unacknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request taken this cycle |
| req_cmd_i | input | 4 | Request code |
| req_addr_i | input | ADDR_W | Target address |
| req_len_i | input | LEN_W | Payload length in bytes |
| wdata_valid_i | input | 1 | Write payload byte valid |
| wdata_ready_o | output | 1 | Write payload byte taken |
| wdata_i | input | 8 | Write payload byte |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_ready_i | input | 1 | Engine takes transmit byte |
| tx_data_o | output | 8 | Transmit byte |
| tx_last_o | output | 1 | Final transmit byte |
| rx_status_valid_i | input | 1 | Engine status strobe |
| rx_status_i | input | 8 | Engine status/acknowledge byte |
| rx_count_i | input | CNT_W | Bytes the engine will return |
| rx_valid_i | input | 1 | Engine returned data byte valid |
| rx_data_i | input | 8 | Engine returned data byte |
| rd_valid_o | output | 1 | Forwarded read byte valid |
| rd_data_o | output | 8 | Forwarded read byte |
| done_valid_o | output | 1 | Completion record valid |
| done_ack_i | input | 1 | Completion consumed |
| done_err_o | output | 3 | Error class |
| done_reply_o | output | 4 | Reply code |
| done_count_o | output | LEN_W | Result byte count |
| busy_o | output | 1 | Transaction in flight |

## Verification
The hardest case to reach from the ports is a clamped read in which the engine returns more bytes than were asked for. The forwarder must stop partway through the engine's burst and still stay in step until the burst ends. The bench's engine model answers with an over-long byte count and checks that only the leading bytes appear. Other directed runs toggle tx_ready_i and wdata_valid_i during a 16-byte write so that payload and header transfers stall at both handshakes. During those runs a second request is held on the input while completion is left unacknowledged for several cycles.

// File: rtl/aux_fmt_pkg.sv
package aux_fmt_pkg;
  localparam int HDR_BYTES = 4;
  localparam int HI_W      = $clog2(HDR_BYTES);
  localparam logic [3:0] BARE_NIB = 4'd3;
  localparam logic [3:0] CONT_BIT = 4'b0100;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_TIMEOUT = 3'd1,
    ERR_FLAGS   = 3'd2,
    ERR_LINK    = 3'd3,
    ERR_SIZE    = 3'd4,
    ERR_CMD     = 3'd5
  } aux_err_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_PAY, ST_WAIT, ST_RDAT, ST_DONE
  } aux_st_e;
endpackage

// File: rtl/aux_hdr_build.sv
module aux_hdr_build
  import aux_fmt_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 5
) (
  input  logic [3:0]                  cmd_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [LEN_W-1:0]            len_i,
  input  logic                        is_read_i,
  output logic [HDR_BYTES-1:0][7:0]   hdr_o
);
  logic [23:0]      addr_x;
  logic [LEN_W-1:0] len_m1;
  logic [LEN_W:0]   total;
  logic [3:0]       size_nib;

  always_comb begin
    addr_x   = 24'(addr_i);
    len_m1   = (len_i == '0) ? '0 : len_i - 1'b1;
    total    = (LEN_W+1)'(HDR_BYTES) + (LEN_W+1)'(len_i);
    if (len_i == '0)    size_nib = BARE_NIB;
    else if (is_read_i) size_nib = 4'(HDR_BYTES);
    else                size_nib = total[3:0];
    hdr_o[0] = addr_x[7:0];
    hdr_o[1] = addr_x[15:8];
    hdr_o[2] = {cmd_i, addr_x[19:16]};
    hdr_o[3] = {size_nib, len_m1[3:0]};
  end
endmodule

// File: rtl/aux_reply_decode.sv
module aux_reply_decode
  import aux_fmt_pkg::*;
#(
  parameter int LEN_W = 5,
  parameter int CNT_W = 8
) (
  input  logic [7:0]       status_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic             is_read_i,
  output aux_err_e         err_o,
  output logic [3:0]       reply_o,
  output logic [LEN_W-1:0] count_o
);
  localparam int CW = (CNT_W > LEN_W) ? CNT_W : LEN_W;
  logic [CW-1:0] rx_w, len_w;

  always_comb begin
    rx_w  = CW'(rx_count_i);
    len_w = CW'(req_len_i);
    case (status_i)
      8'd1:    err_o = ERR_TIMEOUT;
      8'd2:    err_o = ERR_FLAGS;
      8'd3:    err_o = ERR_LINK;
      default: err_o = ERR_NONE;
    endcase
    if (err_o != ERR_NONE) begin
      reply_o = '0;
      count_o = '0;
    end else begin
      reply_o = status_i[7:4];
      if (!is_read_i)        count_o = req_len_i;
      else if (rx_w > len_w) count_o = req_len_i;
      else                   count_o = LEN_W'(rx_w);
    end
  end
endmodule

// File: rtl/aux_req_fmt.sv
module aux_req_fmt
  import aux_fmt_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 5,
  parameter int CNT_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [3:0]        req_cmd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              wdata_valid_i,
  output logic              wdata_ready_o,
  input  logic [7:0]        wdata_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_last_o,
  input  logic              rx_status_valid_i,
  input  logic [7:0]        rx_status_i,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o,
  output logic              done_valid_o,
  input  logic              done_ack_i,
  output logic [2:0]        done_err_o,
  output logic [3:0]        done_reply_o,
  output logic [LEN_W-1:0]  done_count_o,
  output logic              busy_o
);
  localparam int IDX_W = $clog2(HDR_BYTES + MAX_LEN + 1);

  aux_st_e             st_q;
  logic [3:0]          cmd_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [LEN_W-1:0]    len_q;
  logic                rd_q;
  logic [IDX_W-1:0]    idx_q;
  logic [CNT_W-1:0]    rx_left_q;
  logic [LEN_W-1:0]    fwd_left_q;
  aux_err_e            err_q;
  logic [3:0]          reply_q;
  logic [LEN_W-1:0]    count_q;

  logic [3:0]          cmd_m;
  logic                cmd_ok, size_bad, accept;
  logic                hdr_last, pay_last;
  logic [HDR_BYTES-1:0][7:0] hdr;
  aux_err_e            dec_err;
  logic [3:0]          dec_reply;
  logic [LEN_W-1:0]    dec_count;

  assign cmd_m    = req_cmd_i & ~CONT_BIT;
  assign cmd_ok   = (cmd_m == 4'd0) || (cmd_m == 4'd1) || (cmd_m == 4'd8) || (cmd_m == 4'd9);
  assign size_bad = req_len_i > LEN_W'(MAX_LEN);
  assign accept   = req_valid_i && (st_q == ST_IDLE);

  aux_hdr_build #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_hdr (
    .cmd_i     (cmd_q),
    .addr_i    (addr_q),
    .len_i     (len_q),
    .is_read_i (rd_q),
    .hdr_o     (hdr)
  );

  aux_reply_decode #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_dec (
    .status_i   (rx_status_i),
    .rx_count_i (rx_count_i),
    .req_len_i  (len_q),
    .is_read_i  (rd_q),
    .err_o      (dec_err),
    .reply_o    (dec_reply),
    .count_o    (dec_count)
  );

  assign hdr_last = idx_q == IDX_W'(HDR_BYTES - 1);
  assign pay_last = idx_q == IDX_W'(len_q - 1'b1);

  always_comb begin
    tx_valid_o    = 1'b0;
    tx_data_o     = '0;
    tx_last_o     = 1'b0;
    wdata_ready_o = 1'b0;
    case (st_q)
      ST_HDR: begin
        tx_valid_o = 1'b1;
        tx_data_o  = hdr[idx_q[HI_W-1:0]];
        tx_last_o  = hdr_last && (rd_q || len_q == '0);
      end
      ST_PAY: begin
        tx_valid_o    = wdata_valid_i;
        tx_data_o     = wdata_i;
        tx_last_o     = pay_last;
        wdata_ready_o = tx_ready_i;
      end
      default: ;
    endcase
  end

  assign rd_valid_o   = (st_q == ST_RDAT) && rx_valid_i && (fwd_left_q != '0);
  assign rd_data_o    = rx_data_i;
  assign req_ready_o  = st_q == ST_IDLE;
  assign busy_o       = st_q != ST_IDLE;
  assign done_valid_o = st_q == ST_DONE;
  assign done_err_o   = err_q;
  assign done_reply_o = reply_q;
  assign done_count_o = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cmd_q      <= '0;
      addr_q     <= '0;
      len_q      <= '0;
      rd_q       <= 1'b0;
      idx_q      <= '0;
      rx_left_q  <= '0;
      fwd_left_q <= '0;
      err_q      <= ERR_NONE;
      reply_q    <= '0;
      count_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          cmd_q   <= req_cmd_i;
          addr_q  <= req_addr_i;
          len_q   <= req_len_i;
          rd_q    <= cmd_m[0];
          idx_q   <= '0;
          reply_q <= '0;
          count_q <= '0;
          if (size_bad) begin
            err_q <= ERR_SIZE;
            st_q  <= ST_DONE;
          end else if (!cmd_ok) begin
            err_q <= ERR_CMD;
            st_q  <= ST_DONE;
          end else begin
            err_q <= ERR_NONE;
            st_q  <= ST_HDR;
          end
        end
        ST_HDR: if (tx_ready_i) begin
          idx_q <= hdr_last ? '0 : idx_q + 1'b1;
          if (hdr_last) st_q <= (!rd_q && len_q != '0) ? ST_PAY : ST_WAIT;
        end
        ST_PAY: if (tx_ready_i && wdata_valid_i) begin
          idx_q <= idx_q + 1'b1;
          if (pay_last) st_q <= ST_WAIT;
        end
        ST_WAIT: if (rx_status_valid_i) begin
          err_q      <= dec_err;
          reply_q    <= dec_reply;
          count_q    <= dec_count;
          fwd_left_q <= dec_count;
          rx_left_q  <= rx_count_i;
          if (dec_err != ERR_NONE || !rd_q || rx_count_i == '0) st_q <= ST_DONE;
          else                                                   st_q <= ST_RDAT;
        end
        ST_RDAT: if (rx_valid_i) begin
          rx_left_q <= rx_left_q - 1'b1;
          if (fwd_left_q != '0) fwd_left_q <= fwd_left_q - 1'b1;
          if (rx_left_q == CNT_W'(1)) st_q <= ST_DONE;
        end
        ST_DONE: if (done_ack_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_req_fmt_chk.sv
module aux_req_fmt_chk #(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             busy_o,
  input logic             tx_valid_o,
  input logic             tx_ready_i,
  input logic             rd_valid_o,
  input logic             done_valid_o,
  input logic             done_ack_i,
  input logic [2:0]       done_err_o,
  input logic [3:0]       done_reply_o,
  input logic [LEN_W-1:0] done_count_o
);
  localparam int TXC_W = $clog2(MAX_LEN + 8);
  logic [TXC_W-1:0] tx_cnt;
  logic [TXC_W-1:0] rd_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_cnt <= '0;
      rd_cnt <= '0;
    end else if (req_valid_i && req_ready_o) begin
      tx_cnt <= '0;
      rd_cnt <= '0;
    end else begin
      if (tx_valid_o && tx_ready_i) tx_cnt <= tx_cnt + 1'b1;
      if (rd_valid_o)               rd_cnt <= rd_cnt + 1'b1;
    end
  end

  a_r4_tx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt <= TXC_W'(MAX_LEN + 4));

  a_r8_rd_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cnt <= TXC_W'(MAX_LEN));

  a_r11_tx_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> busy_o);

  a_r11_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_valid_o && !done_ack_i) |=>
      (done_valid_o && $stable(done_count_o) && $stable(done_err_o) && $stable(done_reply_o)));

  a_r7_err_zero_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_valid_o && done_err_o != 3'd0) |-> (done_count_o == '0 && done_reply_o == 4'd0));

  a_r11_quiet_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o |-> (!tx_valid_o && !rd_valid_o));
endmodule

bind aux_req_fmt aux_req_fmt_chk #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .busy_o       (busy_o),
  .tx_valid_o   (tx_valid_o),
  .tx_ready_i   (tx_ready_i),
  .rd_valid_o   (rd_valid_o),
  .done_valid_o (done_valid_o),
  .done_ack_i   (done_ack_i),
  .done_err_o   (done_err_o),
  .done_reply_o (done_reply_o),
  .done_count_o (done_count_o)
);

// File: tb/aux_req_fmt_tb.sv
module aux_req_fmt_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;
  // {cmd, addr, len, status, engine count}
  localparam logic [44:0] VEC [NVEC] = '{
    {4'h8, 20'h12345, 5'd2,  8'h00, 8'd0},
    {4'h9, 20'hABCDE, 5'd4,  8'h00, 8'd4},
    {4'h1, 20'h00050, 5'd3,  8'h00, 8'd6},
    {4'h9, 20'h00100, 5'd0,  8'h00, 8'd0},
    {4'h0, 20'h00050, 5'd0,  8'h00, 8'd0},
    {4'hC, 20'hF0F0F, 5'd16, 8'h20, 8'd0},
    {4'h9, 20'h00200, 5'd4,  8'h01, 8'd4},
    {4'h8, 20'h00300, 5'd1,  8'h02, 8'd0},
    {4'h5, 20'h00400, 5'd2,  8'h03, 8'd2},
    {4'h9, 20'h00500, 5'd17, 8'h00, 8'd0},
    {4'h2, 20'h00600, 5'd2,  8'h00, 8'd0},
    {4'hA, 20'h00700, 5'd1,  8'h00, 8'd0},
    {4'h9, 20'h54321, 5'd8,  8'h10, 8'd2}
  };

  logic clk_i = 0, rst_ni = 0;
  logic req_valid_i = 0, req_ready_o;
  logic [3:0] req_cmd_i = 0;
  logic [19:0] req_addr_i = 0;
  logic [4:0] req_len_i = 0;
  logic wdata_valid_i = 0, wdata_ready_o;
  logic [7:0] wdata_i = 0;
  logic tx_valid_o, tx_ready_i = 0, tx_last_o;
  logic [7:0] tx_data_o;
  logic rx_status_valid_i = 0;
  logic [7:0] rx_status_i = 0, rx_count_i = 0, rx_data_i = 0;
  logic rx_valid_i = 0;
  logic rd_valid_o;
  logic [7:0] rd_data_o;
  logic done_valid_o, done_ack_i = 0, busy_o;
  logic [2:0] done_err_o;
  logic [3:0] done_reply_o;
  logic [4:0] done_count_o;

  int tests = 0, fails = 0;
  logic [7:0] txb [32];
  logic [7:0] rdb [32];
  int ntx, nrd;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  aux_req_fmt u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [44:0] v, input bit stress);
    logic [3:0] cmd; logic [19:0] addr; logic [4:0] len; logic [7:0] sts, rxc;
    logic [3:0] cm; bit rd, cmd_ok, bad_size, eng_err;
    int exp_err, exp_cnt, exp_ntx, stage, widx, rxk, cyc;
    bit seen_done;
    {cmd, addr, len, sts, rxc} = v;
    cm = cmd & 4'b1011;
    rd = cm[0];
    cmd_ok = (cm == 0) || (cm == 1) || (cm == 8) || (cm == 9);
    bad_size = len > 16;
    eng_err = (sts == 1) || (sts == 2) || (sts == 3);
    if (bad_size) exp_err = 4;
    else if (!cmd_ok) exp_err = 5;
    else if (eng_err) exp_err = int'(sts);
    else exp_err = 0;
    if (exp_err != 0) exp_cnt = 0;
    else if (!rd) exp_cnt = int'(len);
    else exp_cnt = (int'(rxc) > int'(len)) ? int'(len) : int'(rxc);
    exp_ntx = (bad_size || !cmd_ok) ? 0 : 4 + ((rd || len == 0) ? 0 : int'(len));
    ntx = 0; nrd = 0; stage = 0; widx = 0; rxk = 0; seen_done = 0;

    @(negedge clk_i);
    req_valid_i = 1; req_cmd_i = cmd; req_addr_i = addr; req_len_i = len;
    #1 chk(req_ready_o === 1'b1, "R11 idle ready", int'(req_ready_o), 1);
    for (cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk_i);
      if (stress) begin
        req_valid_i = 1; req_cmd_i = 4'h8; req_len_i = 5'd5; req_addr_i = 20'h0;
      end else req_valid_i = 0;
      tx_ready_i        = stress ? cyc[0] : 1'b1;
      wdata_valid_i     = stress ? !cyc[1] : 1'b1;
      wdata_i           = 8'hA0 + 8'(widx);
      rx_status_valid_i = (stage == 1);
      rx_status_i       = sts;
      rx_count_i        = rxc;
      rx_valid_i        = (stage == 2) && (rxk < int'(rxc)) && !eng_err;
      rx_data_i         = 8'h50 + 8'(rxk);
      #1;
      if (done_valid_o) begin seen_done = 1; break; end
      if (stage == 1) stage = 2;
      if (tx_valid_o && tx_ready_i) begin
        if (ntx < 32) txb[ntx] = tx_data_o;
        ntx++;
        if (tx_last_o) stage = 1;
      end
      if (wdata_ready_o && wdata_valid_i) widx++;
      if (rd_valid_o) begin
        if (nrd < 32) rdb[nrd] = rd_data_o;
        nrd++;
      end
      if (rx_valid_i) rxk++;
    end
    rx_status_valid_i = 0; rx_valid_i = 0;
    chk(seen_done, "R11 completion seen", int'(seen_done), 1);
    chk(ntx == exp_ntx, (exp_ntx == 0) ? "R5/R6 tx byte count" : "R4 tx byte count", ntx, exp_ntx);
    if (exp_ntx >= 4 && ntx >= 4) begin
      chk(txb[0] == addr[7:0], "R1 byte0", int'(txb[0]), int'(addr[7:0]));
      chk(txb[1] == addr[15:8], "R1 byte1", int'(txb[1]), int'(addr[15:8]));
      chk(txb[2] == {cmd, addr[19:16]}, "R1 byte2", int'(txb[2]), int'({cmd, addr[19:16]}));
      chk(txb[3][3:0] == ((len == 0) ? 4'd0 : 4'(len - 1)), "R2 len nibble",
          int'(txb[3][3:0]), int'((len == 0) ? 4'd0 : 4'(len - 1)));
      chk(txb[3][7:4] == ((len == 0) ? 4'd3 : rd ? 4'd4 : 4'(4 + int'(len))), "R3 size nibble",
          int'(txb[3][7:4]), int'((len == 0) ? 4'd3 : rd ? 4'd4 : 4'(4 + int'(len))));
      for (int j = 4; j < exp_ntx && j < ntx; j++)
        chk(txb[j] == 8'hA0 + 8'(j - 4), "R4 payload byte", int'(txb[j]), int'(8'hA0 + 8'(j - 4)));
    end
    chk(int'(done_err_o) == exp_err, "R5/R6/R7 error class", int'(done_err_o), exp_err);
    chk(int'(done_count_o) == exp_cnt, rd ? "R8 read count" : "R9 write count",
        int'(done_count_o), exp_cnt);
    chk(done_reply_o == ((exp_err != 0) ? 4'd0 : sts[7:4]), "R10 reply code",
        int'(done_reply_o), int'((exp_err != 0) ? 4'd0 : sts[7:4]));
    chk(nrd == ((rd && exp_err == 0) ? exp_cnt : 0), "R8 forwarded count", nrd,
        (rd && exp_err == 0) ? exp_cnt : 0);
    for (int j = 0; j < nrd && j < 32; j++)
      chk(rdb[j] == 8'h50 + 8'(j), "R8 forwarded data", int'(rdb[j]), int'(8'h50 + 8'(j)));
    if (stress) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk_i); #1;
        chk(done_valid_o && done_count_o == 5'(exp_cnt) && !req_ready_o, "R11 held record",
            int'(done_count_o), exp_cnt);
      end
    end
    @(negedge clk_i);
    req_valid_i = 0; done_ack_i = 1;
    @(negedge clk_i);
    done_ack_i = 0;
    #1 chk(req_ready_o && !busy_o && !done_valid_o, "R11 idle after ack", int'(busy_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2);
    #1 chk(req_ready_o && !busy_o && !tx_valid_o && !done_valid_o && !rd_valid_o,
           "R11 reset state", int'(busy_o), 0);
    rst_ni = 1;
    for (int i = 0; i < NVEC; i++) run(VEC[i], 1'b0);
    // backpressure, ignored second request, late acknowledge
    run({4'h8, 20'h13579, 5'd16, 8'h00, 8'd0}, 1'b1);
    run({4'h9, 20'h2468A, 5'd3,  8'h30, 8'd9}, 1'b1);
    run({4'hD, 20'h00001, 5'd2,  8'h00, 8'd1}, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule